// File: doc/BRIEF.md
# I2C Slave Byte Receiver with Clock Stretching

This block receives writes addressed to it on an I2C bus. It oversamples SCL and SDA on the system clock and finds start and stop conditions. It checks the first byte after each start against a programmed 7-bit address. When that byte selects it for a write, it acknowledges the address and every byte that follows.

Each received byte is handed to a host through a read register and a full flag. The byte written for the address is itself delivered first, and the host discards it. If the host has not yet collected the previous byte when a new byte finishes, the block holds SCL low until the host reads. The acknowledge level is chosen by an input that is sampled once per frame. Both bus lines are open-drain and are modelled as pull-low enables.

Top module: `i2c_slave_rx`

## Requirements
- R1: With `enable_i` low the block never pulls SCL or SDA, acknowledges nothing and keeps `rx_full_o` at 0.
- R2: A start is SDA falling while SCL is high, and it begins an address frame. A stop is SDA rising while SCL is high, and it returns the block to idle. Clocks after a stop with no new start are ignored.
- R3: Bits are taken MSB first on SCL rising edges. The first byte after a start is the address frame: bits 7..1 are the address, and bit 0 is the direction, where 0 means write.
- R4: In a selected frame, SDA is pulled low during the 9th clock when the latched acknowledge level is 0. SDA stays released when that level is 1.
- R5: On an address match with direction 0, the address byte is placed in `rd_data_o` and `rx_full_o` is set, for a discard read.
- R6: After the address, each data byte is moved to `rd_data_o` at its 8th rising SCL edge when the flag is clear, and `rx_full_o` is set.
- R7: If the previous byte is still unread at the 8th falling SCL edge, `scl_oe_o` holds SCL low and `rd_data_o` keeps the old byte. After the host reads, the new byte is moved in and SCL is released.
- R8: `ack_level_i` is sampled at the first rising SCL edge of each frame. A change made later in that frame affects only the next frame.
- R9: An address mismatch, or a direction bit of 1, leaves SDA released, stores nothing, and causes the bus to be ignored until the next start.
- R10: A cycle with `rd_stb_i` high while `rx_full_o` is set clears `rx_full_o` at that clock edge.
- R11: A repeated start, with no stop in between, begins a new address frame that is evaluated afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Block enable |
| own_addr_i | input | 7 | Own 7-bit slave address |
| ack_level_i | input | 1 | Acknowledge level: 0 ACK, 1 NACK |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| rd_stb_i | input | 1 | Host read strobe for the read register |
| rd_data_o | output | 8 | Read register |
| rx_full_o | output | 1 | Receive-data-full flag |
| scl_oe_o | output | 1 | Pull SCL low (stretch) |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge) |

## Verification
The bench goes after stretching by leaving a byte unread. A design that overwrote the register instead of holding SCL would lose the first byte, and one that never released SCL would hang the bus. It changes the acknowledge level in the middle of a byte. A design that did not latch the level per frame would NACK the byte in progress instead of the next one. It also sends a wrong address, a read-direction address, clocks after a stop and a repeated start. A design that skipped the address check, or failed to reset it on a start, would acknowledge or store bytes that were not meant for it.

// File: rtl/i2c_slave_rx_pkg.sv
package i2c_slave_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } rx_state_e;
endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-1:0], d};
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/i2c_rx_shreg.sv
module i2c_rx_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] shift_in(input logic [W-1:0] cur, input logic b);
    return {cur[W-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= shift_in(q, din);
  end
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_slave_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = DATA_W - 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ack_level_i,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              rd_stb_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rx_full_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  localparam int CW = $clog2(DATA_W + 2);
  localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);
  localparam logic [CW-1:0] ACK_CNT  = CW'(DATA_W);
  localparam logic [CW-1:0] END_CNT  = CW'(DATA_W + 1);

  function automatic logic addr_match(input logic [DATA_W-1:0] b, input logic [ADDR_W-1:0] own);
    return (b[DATA_W-1:1] == own) && !b[0];
  endfunction

  // index 0: SCL, index 1: SDA
  logic [1:0] raw, lvl, rise, fall;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw[g]),
      .lvl(lvl[g]), .rise(rise[g]), .fall(fall[g])
    );
  end

  rx_state_e         state;
  logic [CW-1:0]     bit_cnt;
  logic              ack_q, sda_drv, stretch_q, byte_pending, full_q;
  logic [DATA_W-1:0] shreg_q, rd_q;

  // named internal events
  logic start_ev, stop_ev, frame_on, scl_up, scl_dn, shift_en, byte_done, addr_ok, ignoring;
  logic [DATA_W-1:0] byte_val;

  assign start_ev  = enable_i & fall[1] & lvl[0];
  assign stop_ev   = enable_i & rise[1] & lvl[0];
  assign frame_on  = (state == ST_ADDR) || (state == ST_DATA);
  assign scl_up    = rise[0];
  assign scl_dn    = fall[0];
  assign shift_en  = enable_i & frame_on & scl_up & !start_ev & !stop_ev & (bit_cnt < ACK_CNT);
  assign byte_done = shift_en & (bit_cnt == LAST_BIT);
  assign byte_val  = {shreg_q[DATA_W-2:0], lvl[1]};
  assign addr_ok   = addr_match(byte_val, own_addr_i);
  assign ignoring  = (state == ST_SKIP);

  i2c_rx_shreg #(.W(DATA_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(lvl[1]), .q(shreg_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; bit_cnt <= '0; ack_q <= 1'b0; sda_drv <= 1'b0;
      stretch_q <= 1'b0; byte_pending <= 1'b0; full_q <= 1'b0; rd_q <= '0;
    end else if (!enable_i) begin
      state <= ST_IDLE; bit_cnt <= '0; ack_q <= 1'b0; sda_drv <= 1'b0;
      stretch_q <= 1'b0; byte_pending <= 1'b0; full_q <= 1'b0;
    end else begin
      // host side
      if (rd_stb_i) full_q <= 1'b0;
      if (byte_pending && !full_q) begin
        rd_q <= shreg_q; full_q <= 1'b1; byte_pending <= 1'b0;
      end
      if (!byte_pending) stretch_q <= 1'b0;
      // bus side
      if (start_ev) begin
        state <= ST_ADDR; bit_cnt <= '0; sda_drv <= 1'b0;
      end else if (stop_ev) begin
        state <= ST_IDLE; bit_cnt <= '0; sda_drv <= 1'b0;
      end else if (frame_on) begin
        if (scl_up) begin
          if (bit_cnt == '0) ack_q <= ack_level_i;
          if (bit_cnt < ACK_CNT) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (byte_done) begin
              if (state == ST_DATA || addr_ok) byte_pending <= 1'b1;
              else begin
                state <= ST_SKIP; bit_cnt <= '0;
              end
            end
          end else begin
            bit_cnt <= END_CNT;
          end
        end else if (scl_dn) begin
          if (bit_cnt == ACK_CNT) begin
            sda_drv <= !ack_q;
            if (byte_pending) stretch_q <= 1'b1;
          end else if (bit_cnt == END_CNT) begin
            sda_drv <= 1'b0; bit_cnt <= '0;
            if (state == ST_ADDR) state <= ST_DATA;
          end
        end
      end
    end
  end

  assign rd_data_o = rd_q;
  assign rx_full_o = full_q;
  assign scl_oe_o  = stretch_q;
  assign sda_oe_o  = sda_drv;
endmodule

// File: rtl/i2c_slave_rx_chk.sv
module i2c_slave_rx_chk #(
  parameter int DATA_W = 8,
  parameter int CW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable_i,
  input logic              rd_stb_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rx_full_o,
  input logic              scl_oe_o,
  input logic              sda_oe_o,
  input logic              byte_pending,
  input logic              ignoring,
  input logic [CW-1:0]     bit_cnt
);
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (!sda_oe_o && !scl_oe_o && !rx_full_o));

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && rx_full_o && rd_stb_i) |=> !rx_full_o);

  a_r7_hold_unread: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full_o && !rd_stb_i) |=> $stable(rd_data_o));

  a_r7_stretch_has_pending: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe_o |-> $past(byte_pending));

  a_r6_flag_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full_o) |-> $past(byte_pending));

  a_r4_ack_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> (bit_cnt == CW'(DATA_W) || bit_cnt == CW'(DATA_W + 1)));

  a_r9_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_oe_o);
endmodule

bind i2c_slave_rx i2c_slave_rx_chk #(.DATA_W(DATA_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .rd_stb_i(rd_stb_i),
  .rd_data_o(rd_data_o), .rx_full_o(rx_full_o), .scl_oe_o(scl_oe_o),
  .sda_oe_o(sda_oe_o), .byte_pending(byte_pending), .ignoring(ignoring),
  .bit_cnt(bit_cnt)
);

// File: tb/i2c_slave_rx_tb_top.sv
module i2c_slave_rx_tb_top;
  localparam int Q = 25;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0, rst_n = 1'b0, enable_i = 1'b0, ack_level_i = 1'b0, rd_stb_i = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [6:0] own_addr_i = OWN;
  logic scl_i, sda_i, rx_full_o, scl_oe_o, sda_oe_o;
  logic [7:0] rd_data_o;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  assign scl_i = scl_m & ~scl_oe_o;
  assign sda_i = sda_m & ~sda_oe_o;

  i2c_slave_rx dut_i (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .own_addr_i(own_addr_i),
    .ack_level_i(ack_level_i), .scl_i(scl_i), .sda_i(sda_i), .rd_stb_i(rd_stb_i),
    .rd_data_o(rd_data_o), .rx_full_o(rx_full_o), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
  );

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rw);
    return {a, rw};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; gap(Q); scl_m = 1'b1; gap(Q); sda_m = 1'b0; gap(Q); scl_m = 1'b0; gap(Q);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; gap(Q); scl_m = 1'b1; gap(Q); sda_m = 1'b1; gap(Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; gap(Q);
    scl_m = 1'b1;
    while (!scl_i) @(negedge clk);
    gap(Q / 2); s = sda_i; gap(Q / 2);
    scl_m = 1'b0; gap(Q);
  endtask

  // chg_bit: bit index before which ack_level_i is changed to chg_val (-1: none)
  task automatic send_byte(input logic [7:0] b, input int chg_bit, input logic chg_val,
                           output logic ackbit);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      if (i == chg_bit) ack_level_i = chg_val;
      clk_bit(b[i], s);
    end
    clk_bit(1'b1, ackbit);
  endtask

  task automatic host_read(output logic [7:0] d);
    rd_stb_i = 1'b1; d = rd_data_o;
    @(negedge clk); rd_stb_i = 1'b0;
    chk("R10 flag cleared by read", rx_full_o, 1'b0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic ak;
    logic [7:0] d, b, a2, b2;
    int unsigned seed;
    seed = $urandom(32'h5eed);
    gap(5); rst_n = 1'b1; gap(2);
    chk("R1 reset full", rx_full_o, 0);
    chk("R1 reset scl_oe", scl_oe_o, 0);
    chk("R1 reset sda_oe", sda_oe_o, 0);

    // R1 disabled
    do_start(); send_byte(addr_byte(OWN, 1'b0), -1, 1'b0, ak);
    chk("R1 no ack when disabled", ak, 1);
    chk("R1 no flag when disabled", rx_full_o, 0);
    do_stop(); enable_i = 1'b1; gap(4);

    // R3/R4/R5 address match and discard read
    do_start(); send_byte(addr_byte(OWN, 1'b0), -1, 1'b0, ak);
    chk("R4 address ack", ak, 0);
    chk("R5 flag after address", rx_full_o, 1);
    chk("R5 address byte in register", rd_data_o, addr_byte(OWN, 1'b0));
    host_read(d);
    chk("R3 discard read value", d, {OWN, 1'b0});

    // R6 random data bytes
    for (int k = 0; k < 8; k++) begin
      b = 8'($urandom);
      send_byte(b, -1, 1'b0, ak);
      chk("R4 data ack", ak, 0);
      chk("R6 flag set", rx_full_o, 1);
      chk("R6 data value", rd_data_o, b);
      gap($urandom_range(1, 30));
      host_read(d);
    end

    // R8 mid-frame ack change
    b = 8'hA5;
    send_byte(b, 4, 1'b1, ak);
    chk("R8 mid-frame change not applied", ak, 0);
    host_read(d);
    chk("R6 byte before nack", d, b);
    send_byte(8'h3C, -1, 1'b1, ak);
    chk("R8 change applied next frame", ak, 1);
    chk("R6 nacked byte stored", rd_data_o, 8'h3C);
    host_read(d);
    ack_level_i = 1'b0;

    // R7 stretching
    a2 = 8'h5E; b2 = 8'hC3;
    send_byte(a2, -1, 1'b0, ak);
    chk("R7 first byte ack", ak, 0);
    fork
      begin : master
        logic k2;
        send_byte(b2, -1, 1'b0, k2);
        chk("R7 stretched byte ack", k2, 0);
      end
      begin : host
        int n;
        logic [7:0] dd;
        n = 0;
        while (!scl_oe_o && n < 3000) begin @(negedge clk); n++; end
        chk("R7 stretch asserted", scl_oe_o, 1);
        chk("R7 old byte kept", rd_data_o, a2);
        gap(120);
        chk("R7 still holding SCL", scl_oe_o, 1);
        chk("R7 SCL line low", scl_i, 0);
        host_read(dd);
        chk("R7 read old byte", dd, a2);
        gap(6);
        chk("R7 released after read", scl_oe_o, 0);
        chk("R7 new byte moved in", rd_data_o, b2);
      end
    join
    host_read(d);
    do_stop();

    // R9 mismatch
    do_start(); send_byte(addr_byte(OWN ^ 7'h01, 1'b0), -1, 1'b0, ak);
    chk("R9 mismatch no ack", ak, 1);
    chk("R9 mismatch nothing stored", rx_full_o, 0);
    send_byte(8'h77, -1, 1'b0, ak);
    chk("R9 ignored data no ack", ak, 1);
    chk("R9 ignored data not stored", rx_full_o, 0);
    do_stop();

    // R9 read direction
    do_start(); send_byte(addr_byte(OWN, 1'b1), -1, 1'b0, ak);
    chk("R9 read direction no ack", ak, 1);
    chk("R9 read direction not stored", rx_full_o, 0);
    do_stop();

    // R2 clocks after stop ignored
    send_byte(addr_byte(OWN, 1'b0), -1, 1'b0, ak);
    chk("R2 no start no ack", ak, 1);
    chk("R2 no start no flag", rx_full_o, 0);

    // R11 repeated start
    do_start(); send_byte(addr_byte(OWN, 1'b0), -1, 1'b0, ak);
    chk("R11 first address ack", ak, 0);
    host_read(d);
    send_byte(8'h19, -1, 1'b0, ak);
    host_read(d);
    chk("R6 data before restart", d, 8'h19);
    do_start(); send_byte(addr_byte(OWN ^ 7'h02, 1'b0), -1, 1'b0, ak);
    chk("R11 restart wrong address", ak, 1);
    do_start(); send_byte(addr_byte(OWN, 1'b0), -1, 1'b0, ak);
    chk("R11 restart own address", ak, 0);
    chk("R11 address byte after restart", rd_data_o, addr_byte(OWN, 1'b0));
    host_read(d);
    do_stop();

    // R1 disable clears state
    enable_i = 1'b0; gap(3);
    chk("R1 outputs released", {scl_oe_o, sda_oe_o, rx_full_o}, 3'b000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule